// File: doc/BRIEF.md
# Interrupt Controller Register Window Decoder

This block sits in front of a memory-mapped interrupt controller. It owns one 256 KiB register window whose base address software programs. It checks every host read or write against that window. A claimed access goes to one of six internal regions: global, timer, message-signalled, summary, source and per-CPU. The block hands the region its region-relative offset and sends back read data or an error flag.

The block enforces the access rules. Writes must be full, word-aligned 32-bit writes. Reads may be a full word or a single byte, and a byte read takes one lane of the addressed word. Registers sit on a 16-byte stride. A read off that stride returns all ones, and a write off that stride is dropped. The register contents of each region are small stubs with fixed reset values, so that the decode can be observed.

A request is presented for one cycle on `req_*`. The response appears on `rsp_*` in the next cycle, with the data and the error flag together. `rsp_hit` tells the host whether this block claimed the access.

Top module: `irq_regwin_decoder`

## Requirements
- R1: After reset the base address is zero. While the base is zero, no access is claimed: the response has hit=0, err=0 and rdata=0.
- R2: A base write is rejected if any of the low 18 bits of the written value is set. In that case `base_wr_rej` is high in the same cycle and the base is unchanged. Any other base write loads the base at the next clock edge.
- R3: An access is claimed only when the base is nonzero and addr[AW-1:18] equals base[AW-1:18]. An unclaimed access gives hit=0, err=0 and rdata=0, and a write to it changes nothing.
- R4: Window offsets map to regions as follows. Global is 0x0000–0x10EF. Timer is 0x10F0–0x11FF. Message-signalled is 0x1600–0x17FF. Summary is 0x3600–0x39FF. Source is 0x10000–0x1FFFF. Per-CPU is 0x20000–0x3FFFF. The region-relative offset is the window offset minus the region start.
- R5: A claimed access whose offset lies in no region returns err=1 and rdata=0. A write to such an offset has no effect.
- R6: Each cycle with `req_valid` high produces exactly one response in the next cycle. That response carries hit, err and rdata together. No response appears without a request.
- R7: A 4-byte read at a word-aligned address returns the addressed 32-bit register.
- R8: A 1-byte read returns the byte lane chosen by addr[1:0] in rdata[7:0], with rdata[31:8] zero. Lane 0 is bits 7:0 of the word.
- R9: A read is an error, with err=1 and rdata=0, if its size is neither 1 nor 4, or if it is a 4-byte read with addr[1:0] nonzero.
- R10: A write is an error if its size is not 4 or addr[1:0] is nonzero, and such a write has no effect. Every write response has rdata=0.
- R11: Address bits [1:0] are dropped first. If the remaining region-relative offset is not a multiple of 16, a read returns 0xFFFFFFFF and a write is ignored, with err=0 in both cases.
- R12: The global, timer and source regions each hold 4 registers, at region offsets 0x00, 0x10, 0x20 and 0x30. The message-signalled region holds 2 and the summary region holds 1. Each register resets to 0xC0DE0000 | code<<8 | slot, where the codes are: global 0, timer 1, source 2, per-CPU 3, message-signalled 4, summary 5. Other on-stride offsets read 0xFFFFFFFF and ignore writes.
- R13: In the per-CPU region, region-offset bits [16:12] select the CPU index n, and the register for CPU n sits at region offset n<<12. Any n of NCPU or more (default 4), and any nonzero region-offset bits [11:0], read 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_wr_en | input | 1 | Base address write strobe |
| base_wr_data | input | AW | Value for the base address |
| base_wr_rej | output | 1 | Base write refused because the value is misaligned |
| base_addr | output | AW | Current window base address |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | Access was claimed by this window |
| rsp_err | output | 1 | Claimed access was refused |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |

## Verification
The hardest cases to observe are the ones that silently do nothing. These are off-stride writes, writes to unimplemented slots, and writes that land in the old window after a rebase. All of them return a clean response with no error, so the response alone proves nothing. For each one, the stimulus first writes a distinct value to a slot nearby, then issues the ignored write, and then reads that slot back through the normal read path. Rebasing is done in the middle of a run, and the old window is then probed with a write, so any stale decode of the tag bits would corrupt a register that is read afterwards.

// File: rtl/pic_win_pkg.sv
package pic_win_pkg;

  localparam int WIN_BITS    = 18;
  localparam int DATA_W      = 32;
  localparam int NUM_REGIONS = 6;

  typedef enum logic [2:0] {
    RG_GLB = 3'd0,
    RG_TMR = 3'd1,
    RG_SRC = 3'd2,
    RG_CPU = 3'd3,
    RG_MSI = 3'd4,
    RG_SUM = 3'd5
  } region_e;

  // First window offset of each region.
  function automatic logic [WIN_BITS-1:0] region_start(int idx);
    logic [WIN_BITS-1:0] v;
    case (idx)
      0:       v = 18'h00000;
      1:       v = 18'h010F0;
      2:       v = 18'h10000;
      3:       v = 18'h20000;
      4:       v = 18'h01600;
      5:       v = 18'h03600;
      default: v = 18'h3FFFF;
    endcase
    return v;
  endfunction

  // Exclusive end offset of each region; one bit wider so the window top fits.
  function automatic logic [WIN_BITS:0] region_limit(int idx);
    logic [WIN_BITS:0] v;
    case (idx)
      0:       v = 19'h010F0;
      1:       v = 19'h01200;
      2:       v = 19'h20000;
      3:       v = 19'h40000;
      4:       v = 19'h01800;
      5:       v = 19'h03A00;
      default: v = 19'h00000;
    endcase
    return v;
  endfunction

  function automatic int region_slots(int idx, int ncpu);
    int v;
    case (idx)
      0, 1, 2: v = 4;
      3:       v = ncpu;
      4:       v = 2;
      default: v = 1;
    endcase
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] slot_reset(int rid, int slot);
    return 32'hC0DE_0000 | (32'(rid) << 8) | 32'(slot & 8'hFF);
  endfunction

endpackage

// File: rtl/pic_win_base.sv
module pic_win_base #(
  parameter int AW         = 32,
  parameter int ALIGN_BITS = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic          wr_reject,
  output logic [AW-1:0] base_q
);

  logic          load;
  logic [AW-1:0] base_d;

  assign wr_reject = wr_en && (wr_data[ALIGN_BITS-1:0] != '0);
  assign load      = wr_en && !wr_reject;

  always_comb begin
    base_d = base_q;
    if (load) base_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/pic_win_decode.sv
module pic_win_decode
  import pic_win_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]       base_addr,
  input  logic [AW-1:0]       acc_addr,
  output logic                in_window,
  output logic                region_found,
  output region_e             region_sel,
  output logic [WIN_BITS-1:0] region_off
);

  logic [WIN_BITS-1:0]    win_off;
  logic [NUM_REGIONS-1:0] match;
  logic [WIN_BITS-1:0]    sel_start;

  assign win_off   = acc_addr[WIN_BITS-1:0];
  assign in_window = (base_addr != '0) &&
                     (acc_addr[AW-1:WIN_BITS] == base_addr[AW-1:WIN_BITS]);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    assign match[g] = ({1'b0, win_off} >= {1'b0, region_start(g)}) &&
                      ({1'b0, win_off} <  region_limit(g));
  end

  // Lowest-numbered matching region wins (ranges do not overlap).
  always_comb begin
    region_found = |match;
    region_sel   = RG_GLB;
    sel_start    = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        region_sel = region_e'(i[2:0]);
        sel_start  = region_start(i);
      end
    end
  end

  assign region_off = win_off - sel_start;

endmodule

// File: rtl/pic_win_stub.sv
module pic_win_stub
  import pic_win_pkg::*;
#(
  parameter int RID     = 0,
  parameter int SLOTS   = 4,
  parameter bit PER_CPU = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] roff,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic                slot_ok;
  logic [WIN_BITS-1:0] slot_idx;
  logic [DATA_W-1:0]   regs_q [SLOTS];
  logic [DATA_W-1:0]   regs_d [SLOTS];

  if (PER_CPU) begin : g_cpu_slot
    assign slot_idx = {{(WIN_BITS-5){1'b0}}, roff[16:12]};
    assign slot_ok  = !roff[17] && (roff[11:0] == 12'h000) &&
                      (slot_idx < WIN_BITS'(SLOTS));
  end else begin : g_flat_slot
    assign slot_idx = {4'b0000, roff[WIN_BITS-1:4]};
    assign slot_ok  = (roff[3:0] == 4'h0) && (slot_idx < WIN_BITS'(SLOTS));
  end

  always_comb begin
    rdata = '1;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_ok && slot_idx == WIN_BITS'(i)) rdata = regs_q[i];
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      regs_d[i] = (slot_ok && slot_idx == WIN_BITS'(i)) ? wdata : regs_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) regs_q[i] <= slot_reset(RID, i);
    end else if (wr_en) begin
      for (int i = 0; i < SLOTS; i++) regs_q[i] <= regs_d[i];
    end
  end

endmodule

// File: rtl/irq_regwin_decoder.sv
module irq_regwin_decoder
  import pic_win_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [AW-1:0]     base_wr_data,
  output logic              base_wr_rej,
  output logic [AW-1:0]     base_addr,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pic_win_base #(.AW(AW), .ALIGN_BITS(WIN_BITS)) base_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (base_wr_en),
    .wr_data  (base_wr_data),
    .wr_reject(base_wr_rej),
    .base_q   (base_addr)
  );

  logic                in_window;
  logic                region_found;
  region_e             region_sel;
  logic [WIN_BITS-1:0] region_off;

  pic_win_decode #(.AW(AW)) dec_i (
    .base_addr   (base_addr),
    .acc_addr    (req_addr),
    .in_window   (in_window),
    .region_found(region_found),
    .region_sel  (region_sel),
    .region_off  (region_off)
  );

  // Access rule checks.
  logic acc_hit, size_ok, acc_err, wr_go;

  always_comb begin
    if (req_write) size_ok = (req_size == 3'd4) && (req_addr[1:0] == 2'b00);
    else           size_ok = (req_size == 3'd1) ||
                             ((req_size == 3'd4) && (req_addr[1:0] == 2'b00));
  end

  assign acc_hit = req_valid && in_window;
  assign acc_err = acc_hit && (!region_found || !size_ok);
  assign wr_go   = acc_hit && req_write && !acc_err;

  // Region stubs see a word offset: byte lane bits dropped.
  logic [WIN_BITS-1:0]    word_off;
  logic [NUM_REGIONS-1:0] stub_we;
  logic [DATA_W-1:0]      stub_rd [NUM_REGIONS];

  assign word_off = {region_off[WIN_BITS-1:2], 2'b00};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign stub_we[g] = wr_go && (region_sel == region_e'(3'(g)));
    pic_win_stub #(
      .RID    (g),
      .SLOTS  (region_slots(g, NCPU)),
      .PER_CPU(g == int'(RG_CPU))
    ) stub_i (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .wr_en(stub_we[g]),
      .roff (word_off),
      .wdata(req_wdata),
      .rdata(stub_rd[g])
    );
  end

  logic [DATA_W-1:0] word_rd;
  logic [7:0]        lane_byte;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    word_rd = '1;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (region_sel == region_e'(i[2:0])) word_rd = stub_rd[i];
    end
  end

  always_comb begin
    case (region_off[1:0])
      2'd0:    lane_byte = word_rd[7:0];
      2'd1:    lane_byte = word_rd[15:8];
      2'd2:    lane_byte = word_rd[23:16];
      default: lane_byte = word_rd[31:24];
    endcase
  end

  always_comb begin
    rdata_d = '0;
    if (acc_hit && !acc_err && !req_write) begin
      rdata_d = (req_size == 3'd1) ? {24'h000000, lane_byte} : word_rd;
    end
  end

  // Response register: one cycle after the request.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= acc_hit;
      rsp_err   <= acc_err;
      if (req_valid) rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/pic_win_chk.sv
module pic_win_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          base_wr_en,
  input logic [AW-1:0] base_wr_data,
  input logic          base_wr_rej,
  input logic [AW-1:0] base_addr,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [2:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_err,
  input logic [31:0]   rsp_rdata
);

  assert_rej_keeps_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_rej |=> $stable(base_addr));

  assert_base_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_en && !base_wr_rej |=> base_addr == $past(base_wr_data));

  assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_addr[17:0] == 18'h0);

  assert_unmapped_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && base_addr == '0 |=> !rsp_hit);

  assert_tag_mismatch_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_addr[AW-1:18] != base_addr[AW-1:18] |=> !rsp_hit);

  assert_unclaimed_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_err && rsp_rdata == '0);

  assert_resp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  assert_err_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_hit && rsp_rdata == '0);

  assert_byte_read_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size == 3'd1 |=> rsp_rdata[31:8] == 24'h0);

  assert_bad_read_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_size != 3'd1 && req_size != 3'd4
    |=> !rsp_hit || rsp_err);

  assert_bad_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && (req_size != 3'd4 || req_addr[1:0] != 2'b00)
    |=> !rsp_hit || rsp_err);

  assert_write_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> rsp_rdata == '0);

endmodule

bind irq_regwin_decoder pic_win_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .base_wr_en  (base_wr_en),
  .base_wr_data(base_wr_data),
  .base_wr_rej (base_wr_rej),
  .base_addr   (base_addr),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata)
);

// File: tb/irq_regwin_decoder_tb_top.sv
`timescale 1ns/1ps
module irq_regwin_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic        base_wr_rej;
  logic [31:0] base_addr;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  irq_regwin_decoder #(.AW(32), .NCPU(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .base_wr_rej(base_wr_rej), .base_addr(base_addr),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    bit          hit;
    bit          err;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          errors = 0;
  int          checks = 0;
  logic [31:0] base_m = 32'h0;
  logic [31:0] mem [6][32];
  int          rstart [6] = '{'h0, 'h10F0, 'h10000, 'h20000, 'h1600, 'h3600};
  int          rslots [6] = '{4, 4, 4, 4, 2, 1};

  function automatic int find_region(int off);
    if (off < 'h10F0)                    return 0;
    if (off >= 'h10F0  && off < 'h1200)  return 1;
    if (off >= 'h1600  && off < 'h1800)  return 4;
    if (off >= 'h3600  && off < 'h3A00)  return 5;
    if (off >= 'h10000 && off < 'h20000) return 2;
    if (off >= 'h20000 && off < 'h40000) return 3;
    return -1;
  endfunction

  function automatic int find_slot(int rid, int roff);
    int s;
    if (rid == 3) begin
      if ((roff & 'hFFF) != 0) return -1;
      s = roff >> 12;
    end else begin
      if ((roff & 'hF) != 0) return -1;
      s = roff >> 4;
    end
    return (s < rslots[rid]) ? s : -1;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: compute the expectation, push it, drive one request cycle.
  task automatic do_req(bit wr, logic [31:0] addr, int size, logic [31:0] wdata, string tag);
    bit          inwin;
    bit          ok_size;
    bit          err;
    int          off;
    int          rid;
    int          roff;
    int          s;
    logic [31:0] word;
    logic [31:0] d;
    exp_t        e;
    inwin   = (base_m != 0) && (addr[31:18] == base_m[31:18]);
    off     = int'(addr[17:0]);
    rid     = inwin ? find_region(off) : -1;
    ok_size = wr ? (size == 4 && addr[1:0] == 2'b00)
                 : (size == 1 || (size == 4 && addr[1:0] == 2'b00));
    err     = inwin && (rid < 0 || !ok_size);
    d       = 32'h0;
    if (inwin && !err) begin
      roff = (off & ~3) - rstart[rid];
      s    = find_slot(rid, roff);
      if (wr) begin
        if (s >= 0) mem[rid][s] = wdata;
      end else begin
        word = (s >= 0) ? mem[rid][s] : 32'hFFFF_FFFF;
        d    = (size == 1) ? ((word >> (8 * addr[1:0])) & 32'hFF) : word;
      end
    end
    e.hit = inwin; e.err = err; e.data = d; e.tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    req_size = 3'(size); req_wdata = wdata;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(logic [31:0] addr, int size, string tag);
    do_req(1'b0, addr, size, 32'h0, tag);
  endtask

  task automatic wr(logic [31:0] addr, int size, logic [31:0] data, string tag);
    do_req(1'b1, addr, size, data, tag);
  endtask

  task automatic set_base(logic [31:0] v, bit exp_rej, string tag);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = v;
    #1;
    check(base_wr_rej === exp_rej, tag, 32'(base_wr_rej), 32'(exp_rej));
    if (!exp_rej) base_m = v;
    @(negedge clk);
    base_wr_en = 1'b0;
    #1;
    check(base_addr === base_m, tag, base_addr, base_m);
  endtask

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_err !== e.err || rsp_rdata !== e.data) begin
          errors++;
          $display("FAIL %s: actual hit=%0b err=%0b data=%h expected hit=%0b err=%0b data=%h",
                   e.tag, rsp_hit, rsp_err, rsp_rdata, e.hit, e.err, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] b;
    for (int r = 0; r < 6; r++)
      for (int s = 0; s < 32; s++)
        mem[r][s] = 32'hC0DE_0000 | (32'(r) << 8) | 32'(s);
    rst_n = 1'b0; base_wr_en = 1'b0; base_wr_data = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(base_addr === 32'h0, "R1 base reset", base_addr, 32'h0);
    check(rsp_valid === 1'b0, "R6 idle after reset", 32'(rsp_valid), 32'h0);
    rd(32'h0000_0000, 4, "R1 unmapped read");

    set_base(32'h8004_0100, 1'b1, "R2 misaligned base rejected");
    set_base(32'h8004_0000, 1'b0, "R2 aligned base accepted");
    b = 32'h8004_0000;

    rd(32'h8000_0000, 4, "R3 below window");
    rd(32'h8008_0000, 4, "R3 above window");
    rd(32'h8003_FFFC, 4, "R3 just below base");

    rd(b + 32'h0,     4, "R7 global slot0");
    rd(b + 32'h10,    4, "R7 global slot1");
    rd(b + 32'h40,    4, "R12 unimplemented global");
    rd(b + 32'h04,    4, "R11 off-stride read");
    rd(b + 32'h10F0,  4, "R4 timer slot0");
    rd(b + 32'h1100,  4, "R4 timer slot1");
    rd(b + 32'h1610,  4, "R4 msi slot1");
    rd(b + 32'h3600,  4, "R4 summary slot0");
    rd(b + 32'h3610,  4, "R12 summary beyond slots");
    rd(b + 32'h10030, 4, "R4 source slot3");
    rd(b + 32'h10040, 4, "R12 source beyond slots");

    rd(b + 32'h1300, 4, "R5 gap read");
    rd(b + 32'h8000, 4, "R5 gap read high");
    wr(b + 32'h1300, 4, 32'hDEAD_BEEF, "R5 gap write");

    for (int i = 0; i < 4; i++) rd(b + 32'h10 + 32'(i), 1, "R8 byte lane");
    rd(b + 32'h11, 4, "R9 misaligned word read");
    rd(b + 32'h10, 2, "R9 halfword read");
    rd(b + 32'h10, 0, "R9 zero size read");

    wr(b + 32'h10, 4, 32'h1234_5678, "R7 word write");
    rd(b + 32'h10, 4, "R7 readback");
    wr(b + 32'h10, 1, 32'h0000_00AA, "R10 byte write refused");
    wr(b + 32'h12, 4, 32'hAAAA_AAAA, "R10 misaligned write refused");
    rd(b + 32'h10, 4, "R10 readback unchanged");
    wr(b + 32'h14, 4, 32'h5555_5555, "R11 off-stride write");
    rd(b + 32'h10, 4, "R11 readback unchanged");
    rd(b + 32'h15, 1, "R11 byte read off-stride");
    wr(b + 32'h40, 4, 32'h7777_7777, "R12 write unimplemented");
    rd(b + 32'h30, 4, "R12 neighbour unchanged");
    rd(b + 32'h13, 1, "R8 top lane after write");

    rd(b + 32'h20000, 4, "R13 cpu0");
    rd(b + 32'h23000, 4, "R13 cpu3");
    wr(b + 32'h22000, 4, 32'hA5A5_5A5A, "R13 cpu2 write");
    rd(b + 32'h22000, 4, "R13 cpu2 readback");
    rd(b + 32'h24000, 4, "R13 cpu4 absent");
    rd(b + 32'h21010, 4, "R13 page offset nonzero");
    rd(b + 32'h3F000, 4, "R13 cpu31 absent");

    set_base(32'h0004_0000, 1'b0, "R2 rebase");
    rd(32'h8004_0010, 4, "R3 old window unclaimed");
    rd(32'h0004_0010, 4, "R3 new window keeps data");
    wr(32'h8004_0020, 4, 32'h1111_2222, "R3 write to old window");
    rd(32'h0004_0020, 4, "R3 slot untouched by old window");

    set_base(32'h0000_0000, 1'b0, "R1 unmap");
    rd(32'h0000_0010, 4, "R1 unmapped after clear");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6 all responses seen", 32'(sb.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule